// File: doc/BRIEF.md
# Five-Bank Interrupt Request Controller

The controller collects 160 interrupt request lines, grouped as five banks of 32, and presents one request output per bank to a processor. A rising edge on a request line records a pending bit in that bank's status register. Software sets or clears mask bits in the bank's enable register. It acknowledges a pending bit by writing a one to the same status position, and it can raise a request itself through a write-one-to-set register. A bank's output stays high while any bit is both pending and enabled.

A shared vector register packs one 5-bit field per bank. Each field gives the index of the lowest-numbered line in that bank that is pending and enabled, so a handler can read one word and go straight to the right source. The register file sits on a plain 32-bit word bus with a combinational read port and a single-cycle write strobe. The block is normally the only interrupt aggregator between on-chip peripherals and the processor core. By convention, software treats lines 0 to 11 of bank 0 as one group and masks and acknowledges them together using the mask 0x00000FFF.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every register reads 0 and all five bank outputs are low.
- R2: A request line going from 0 to 1 between two rising clock edges sets its status bit after the edge where it is seen high. A line that stays high sets the bit only once: after an acknowledge, the bit stays clear until the line falls and rises again.
- R3: Writing the status register of a bank clears each status bit whose data bit is 1. Bits written with 0 keep their value.
- R4: The enable register of a bank loads the full written word on a write and reads back the stored value. A bank output can rise only when the matching enable bit is 1.
- R5: Bank output n is high in the cycle after (status AND enable) of bank n becomes nonzero. The output-status register of bank n reads (status AND enable).
- R6: Writing the request-set register of a bank sets each status bit whose data bit is 1. Bits written with 0 have no effect.
- R7: If a line's rising edge, or a request-set bit, falls in the same cycle as an acknowledge of that bit, the bit ends up set.
- R8: The vector register holds, in bits [5n+4:5n], the index of the lowest set bit of (status AND enable) of bank n. The field is 0 when that value is 0. Bits 31:25 read 0.
- R9: Bank n (n = 0..4) occupies byte offsets 0x10+0x10*n. The registers sit at +0x0 (status, write-one-to-clear), +0x4 (enable), +0x8 (output status, read only) and +0xC (request set, reads 0). The vector register sits at offset 0x60. Address bits 1:0 are ignored.
- R10: Offsets 0x00 to 0x0C and every offset above 0x60 read 0, and writes to them change nothing. Writes to output-status registers and to the vector register also change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 160 | Request lines; line k of bank n is bit 32*n+k |
| bus_addr_i | input | 8 | Byte offset of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 5 | One request output per bank |

## Verification
The hardest case to reach is a request arriving in the same clock edge that software acknowledges the same bit, because the set must win. Reaching it needs a line edge and a status write to line up exactly. The bench first latches a bit and lets the line fall. In one falling-edge slot it then raises the line again and drives a status write with that bit, and afterwards reads the status back. A long pseudo-random phase also mixes line toggles with writes to every register of every bank. A behavioural model tracks each bank, and the bench compares the outputs on every clock and the read data on every access.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  parameter int unsigned NBANK_DEF = 5;
  parameter int unsigned NLINE_DEF = 32;
  parameter int unsigned DW_DEF    = 32;
  parameter int unsigned AW_DEF    = 8;

  typedef enum logic [1:0] {
    SUB_STAT = 2'd0,
    SUB_EN   = 2'd1,
    SUB_OSR  = 2'd2,
    SUB_SET  = 2'd3
  } sub_e;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned NLINE = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NLINE-1:0] line_i,
  input  logic [NLINE-1:0] ack_i,
  input  logic             en_wr_i,
  input  logic [NLINE-1:0] en_data_i,
  input  logic [NLINE-1:0] set_i,
  output logic [NLINE-1:0] status_o,
  output logic [NLINE-1:0] enable_o,
  output logic [NLINE-1:0] masked_o,
  output logic             req_o
);
  logic [NLINE-1:0] line_q, stat_q, en_q, rise;

  assign rise = line_i & ~line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      line_q <= line_i;
      // set terms after clear: new request beats acknowledge
      stat_q <= (stat_q & ~ack_i) | rise | set_i;
      if (en_wr_i) en_q <= en_data_i;
    end
  end

  assign status_o = stat_q;
  assign enable_o = en_q;
  assign masked_o = stat_q & en_q;
  assign req_o    = |masked_o;

  p_edge_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> (($past(rise) & ~stat_q) == '0));

  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(rise | set_i)) == '0));

  p_ack_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_i) |=> ((stat_q & $past(ack_i & ~rise & ~set_i)) == '0));

  p_enable_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i |=> (en_q == $past(en_data_i)));

  p_sw_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> (($past(set_i) & ~stat_q) == '0));

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ack_i & (rise | set_i))) |=> (($past(ack_i & (rise | set_i)) & ~stat_q) == '0));
endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
  parameter int unsigned W  = 32,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_reg_dec.sv
module irq_reg_dec
  import irq_bank_pkg::*;
#(
  parameter int unsigned NBANK = 5,
  parameter int unsigned NLINE = 32,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [AW-1:0]               addr_i,
  input  logic                        wr_i,
  input  logic [DW-1:0]               wdata_i,
  input  logic [NBANK-1:0][NLINE-1:0] status_i,
  input  logic [NBANK-1:0][NLINE-1:0] enable_i,
  input  logic [NBANK-1:0][NLINE-1:0] masked_i,
  input  logic [DW-1:0]               vec_i,
  output logic [NBANK-1:0][NLINE-1:0] ack_o,
  output logic [NBANK-1:0]            en_wr_o,
  output logic [NBANK-1:0][NLINE-1:0] set_o,
  output logic [DW-1:0]               rdata_o
);
  localparam int unsigned NW      = AW - 4;
  localparam logic [NW-1:0] VEC_NIB = NW'(NBANK + 1);

  logic [NW-1:0]    nib;
  sub_e             sub;
  logic [NBANK-1:0] sel;

  assign nib = addr_i[AW-1:4];
  assign sub = sub_e'(addr_i[3:2]);

  for (genvar n = 0; n < NBANK; n++) begin : g_bank
    assign sel[n]     = (nib == NW'(n + 1));
    assign ack_o[n]   = (wr_i && sel[n] && sub == SUB_STAT) ? wdata_i[NLINE-1:0] : '0;
    assign set_o[n]   = (wr_i && sel[n] && sub == SUB_SET)  ? wdata_i[NLINE-1:0] : '0;
    assign en_wr_o[n] = wr_i && sel[n] && sub == SUB_EN;
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < NBANK; n++) begin
      if (sel[n]) begin
        unique case (sub)
          SUB_STAT: rdata_o = DW'(status_i[n]);
          SUB_EN:   rdata_o = DW'(enable_i[n]);
          SUB_OSR:  rdata_o = DW'(masked_i[n]);
          SUB_SET:  rdata_o = '0;
        endcase
      end
    end
    if (nib == VEC_NIB && sub == SUB_STAT) rdata_o = vec_i;
  end

  p_ctrl_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib == '0) |-> (rdata_o == '0));

  p_one_bank_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en_wr_o));
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int unsigned NBANK = NBANK_DEF,
  parameter int unsigned NLINE = NLINE_DEF,
  parameter int unsigned AW    = AW_DEF,
  parameter int unsigned DW    = DW_DEF,
  localparam int unsigned VW   = $clog2(NLINE),
  localparam int unsigned NIN  = NBANK * NLINE
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NIN-1:0] irq_lines_i,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic           bus_wr_i,
  input  logic [DW-1:0]  bus_wdata_i,
  output logic [DW-1:0]  bus_rdata_o,
  output logic [NBANK-1:0] irq_o
);
  logic [NBANK-1:0][NLINE-1:0] status, enable, masked, ack, set;
  logic [NBANK-1:0]            en_wr;
  logic [NBANK-1:0][VW-1:0]    idx;
  logic [DW-1:0]               vec;

  irq_reg_dec #(.NBANK(NBANK), .NLINE(NLINE), .AW(AW), .DW(DW)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (bus_addr_i),
    .wr_i     (bus_wr_i),
    .wdata_i  (bus_wdata_i),
    .status_i (status),
    .enable_i (enable),
    .masked_i (masked),
    .vec_i    (vec),
    .ack_o    (ack),
    .en_wr_o  (en_wr),
    .set_o    (set),
    .rdata_o  (bus_rdata_o)
  );

  for (genvar n = 0; n < NBANK; n++) begin : g_bank
    irq_bank #(.NLINE(NLINE)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .line_i    (irq_lines_i[n*NLINE +: NLINE]),
      .ack_i     (ack[n]),
      .en_wr_i   (en_wr[n]),
      .en_data_i (bus_wdata_i[NLINE-1:0]),
      .set_i     (set[n]),
      .status_o  (status[n]),
      .enable_o  (enable[n]),
      .masked_o  (masked[n]),
      .req_o     (irq_o[n])
    );

    irq_lowest_enc #(.W(NLINE)) u_enc (
      .vec_i (masked[n]),
      .idx_o (idx[n])
    );

    p_vec_lowest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (masked[n] != '0) |-> (masked[n][idx[n]] &&
        ((masked[n] & ((NLINE'(1) << idx[n]) - NLINE'(1))) == '0)));

    p_vec_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (masked[n] == '0) |-> (vec[n*VW +: VW] == '0));

    p_out_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable[n] == '0) |-> !irq_o[n]);
  end

  always_comb begin
    vec = '0;
    for (int n = 0; n < NBANK; n++) vec[n*VW +: VW] = idx[n];
  end
endmodule

// File: tb/sim_irq_bank_ctrl.sv
`timescale 1ns/1ps
module sim_irq_bank_ctrl;
  localparam int NB = 5;
  localparam int NL = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [159:0] lines = '0;
  logic [7:0]   addr = '0;
  logic         wr = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [4:0]   irq;
  logic         done = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [31:0]  m_stat [NB];
  logic [31:0]  m_en   [NB];
  logic [159:0] m_prev;
  logic [31:0]  seed = 32'h1234_5678;

  always #4 clk = ~clk;

  irq_bank_ctrl u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .irq_lines_i (lines),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_stat[b] = '0;
        m_en[b] = '0;
      end
      m_prev = '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        logic [31:0] rise, ack, set;
        rise = lines[b*NL +: NL] & ~m_prev[b*NL +: NL];
        ack = '0;
        set = '0;
        if (wr && int'(addr[7:4]) == b + 1) begin
          if (addr[3:2] == 2'd0) ack = wdata;
          if (addr[3:2] == 2'd1) m_en[b] = wdata;
          if (addr[3:2] == 2'd3) set = wdata;
        end
        m_stat[b] = (m_stat[b] & ~ack) | rise | set;
      end
      m_prev = lines;
    end
  end

  function automatic logic [31:0] m_vec();
    logic [31:0] v = '0;
    for (int b = 0; b < NB; b++) begin
      logic [31:0] m = m_stat[b] & m_en[b];
      int lo = 0;
      for (int k = 31; k >= 0; k--) if (m[k]) lo = k;
      v = v | (32'(lo) << (5 * b));
    end
    return v;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    int nib = int'(a[7:4]);
    if (nib >= 1 && nib <= NB) begin
      case (a[3:2])
        2'd0: return m_stat[nib-1];
        2'd1: return m_en[nib-1];
        2'd2: return m_stat[nib-1] & m_en[nib-1];
        default: return 32'h0;
      endcase
    end
    if (nib == 6 && a[3:2] == 2'd0) return m_vec();
    return 32'h0;
  endfunction

  function automatic logic [4:0] m_irq();
    logic [4:0] r;
    for (int b = 0; b < NB; b++) r[b] = |(m_stat[b] & m_en[b]);
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock output comparison (R5)
  always @(negedge clk) begin
    if (rst_n && !done) chk("R5 irq_o vs model", 32'(irq), 32'(m_irq()));
  end

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_exp(logic [7:0] a, string tag, logic [31:0] exp);
    @(negedge clk);
    addr = a; wr = 1'b0;
    #1;
    chk(tag, rdata, exp);
    chk({tag, " model"}, rdata, m_read(a));
  endtask

  task automatic pulse(int idx);
    @(negedge clk); lines[idx] = 1'b1;
    @(negedge clk); lines[idx] = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq_o after reset", 32'(irq), 32'h0);
    for (int a = 0; a <= 8'h60; a += 4) rd_exp(8'(a), "R1 reset read", 32'h0);

    // R4/R9: enable load and readback, bank 2 at 0x34
    wr_reg(8'h34, 32'h8000_0001);
    rd_exp(8'h34, "R4 enable readback", 32'h8000_0001);

    // R2/R5/R8: line 31 of bank 2
    pulse(2*NL + 31);
    rd_exp(8'h30, "R2 status after edge", 32'h8000_0000);
    chk("R5 irq_o bank2", 32'(irq), 32'h4);
    rd_exp(8'h38, "R5 output status", 32'h8000_0000);
    rd_exp(8'h60, "R8 vector bank2 field=31", 32'd31 << 10);

    // masked pending line does not affect vector
    pulse(2*NL + 5);
    rd_exp(8'h30, "R2 status two bits", 32'h8000_0020);
    rd_exp(8'h38, "R4 masked bit hidden", 32'h8000_0000);
    rd_exp(8'h60, "R4 vector ignores masked", 32'd31 << 10);
    wr_reg(8'h34, 32'h8000_0021);
    rd_exp(8'h60, "R8 vector lowest=5", 32'd5 << 10);

    // R3: write-one-to-clear
    wr_reg(8'h30, 32'h0000_0020);
    rd_exp(8'h30, "R3 ack clears bit5", 32'h8000_0000);
    wr_reg(8'h30, 32'h0);
    rd_exp(8'h30, "R3 zero write keeps", 32'h8000_0000);

    // R2: held line latches once
    wr_reg(8'h24, 32'hFFFF_FFFF);
    @(negedge clk); lines[NL + 0] = 1'b1;
    @(negedge clk);
    rd_exp(8'h20, "R2 held line set", 32'h1);
    wr_reg(8'h20, 32'h1);
    repeat (3) @(negedge clk);
    rd_exp(8'h20, "R2 held line no relatch", 32'h0);
    chk("R2 irq bank1 low", 32'(irq[1]), 32'h0);
    @(negedge clk); lines[NL + 0] = 1'b0;

    // R6: software set
    wr_reg(8'h5C, 32'h0001_0000);
    rd_exp(8'h50, "R6 sw set status", 32'h0001_0000);
    rd_exp(8'h5C, "R9 set reg reads 0", 32'h0);
    chk("R6 irq bank4 masked", 32'(irq[4]), 32'h0);
    wr_reg(8'h5C, 32'h0);
    rd_exp(8'h50, "R6 zero set no effect", 32'h0001_0000);
    wr_reg(8'h54, 32'h0001_0000);
    chk("R6 irq bank4 on", 32'(irq[4]), 32'h1);
    rd_exp(8'h60, "R8 vector bank4 field=16", (32'd31 << 10) | (32'd16 << 20));

    // R7: new edge and acknowledge in the same cycle, bank 0 bit 3
    pulse(3);
    rd_exp(8'h10, "R7 pre status", 32'h8);
    @(negedge clk);
    lines[3] = 1'b1; addr = 8'h10; wdata = 32'h8; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    rd_exp(8'h10, "R7 set wins over ack", 32'h8);
    @(negedge clk); lines[3] = 1'b0;
    wr_reg(8'h10, 32'h8);
    rd_exp(8'h10, "R3 plain ack bank0", 32'h0);

    // R4: masking drops output
    wr_reg(8'h34, 32'h0);
    chk("R4 irq bank2 masked", 32'(irq[2]), 32'h0);
    rd_exp(8'h38, "R4 osr zero", 32'h0);
    rd_exp(8'h30, "R4 status kept", 32'h8000_0000);

    // R10: inert addresses
    for (int a = 0; a < 16; a += 4) wr_reg(8'(a), 32'hFFFF_FFFF);
    for (int a = 0; a < 16; a += 4) rd_exp(8'(a), "R10 ctrl reads 0", 32'h0);
    wr_reg(8'h58, 32'hFFFF_FFFF);
    rd_exp(8'h58, "R10 osr write ignored", 32'h0001_0000);
    rd_exp(8'h50, "R10 status after osr write", 32'h0001_0000);
    wr_reg(8'h60, 32'hFFFF_FFFF);
    rd_exp(8'h60, "R10 vector write ignored", 32'd16 << 20);
    wr_reg(8'h70, 32'hFFFF_FFFF);
    rd_exp(8'h70, "R10 high offset", 32'h0);
    rd_exp(8'hFC, "R10 top offset", 32'h0);
    for (int b = 0; b < NB; b++) rd_exp(8'(16*b + 20), "R10 enable unaffected", m_read(8'(16*b + 20)));

    // R8: nothing pending in any bank
    for (int b = 0; b < NB; b++) wr_reg(8'(16*b + 16), 32'hFFFF_FFFF);
    rd_exp(8'h60, "R8 vector idle", 32'h0);

    // mixed pseudo-random phase (R2..R10 via model)
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      seed = seed * 32'd1664525 + 32'd1013904223;
      lines[int'(seed[23:16]) % 160] = seed[0];
      if (seed[31:30] == 2'b00) begin
        addr = {4'(1 + int'(seed[10:8]) % NB), seed[3:2], seed[5:4]};
        wdata = seed ^ {seed[15:0], seed[31:16]};
        wr = 1'b1;
      end else begin
        wr = 1'b0;
        addr = seed[12] ? 8'h60 : {4'(1 + int'(seed[10:8]) % NB), seed[3:2], 2'b00};
      end
      #1;
      chk("R9 random read", rdata, m_read(addr));
    end
    @(negedge clk); wr = 1'b0;
    for (int a = 16; a <= 8'h60; a += 4) rd_exp(8'(a), "R9 final map", m_read(8'(a)));

    finish_run();
  end
endmodule